// File: doc/BRIEF.md
# Unaligned Transmit Buffer Realigner

This block fetches a transmit buffer that may begin on any byte of a 32-bit memory and turns it into densely packed words for a transmit FIFO. Every memory read it issues is word aligned: the first read goes to the start address rounded down to a word boundary, and each later read goes one word higher. In the first word read it discards the byte lanes below the start offset. In the last word read it discards the lanes past the buffer end. The useful bytes are shifted down and merged with bytes held over from earlier reads, so that each FIFO word carries four bytes in address order.

A frame may span several buffers. Each buffer command carries an end-of-frame flag. When a buffer does not close its frame, up to three leftover bytes stay in a holding register and are joined with the first bytes of the next buffer. Only the final word of a frame may carry fewer than four bytes. That word reports its valid-byte count and raises the last marker. If the final read leaves more than four bytes to send, the block emits a full word first and then a tail word. Backpressure from the FIFO stalls the reads, and no held byte is lost.

Top module: `txbuf_realign`

## Requirements
- R1: After a synchronous reset, out_valid and rd_ready are 0 and cmd_ready is 1.
- R2: The first read of a buffer is at cmd_addr with its two low bits cleared. Each later read of the same buffer is 4 higher, and rd_addr always has its two low bits at 0.
- R3: A buffer of length L (L at least 1) starting at byte offset o = cmd_addr mod 4 takes exactly ceil((o + L) / 4) read handshakes (rd_valid and rd_ready both high), and no others.
- R4: In the first word read, the lanes below o are discarded. In the last word read, the lanes above lane (o + L - 1) mod 4 are discarded. Byte lane i is rd_data[8i+7:8i] and holds the byte at word address + i.
- R5: The output stream holds exactly the buffer bytes in ascending address order, frames in command order. Lane i of out_data, for i < out_cnt, is the i-th byte of that word.
- R6: Every output word without out_last has out_cnt = 4. out_cnt is always between 1 and 4.
- R7: out_last is raised only on the word holding the final byte of a buffer accepted with cmd_eof = 1. Leftover bytes of a buffer accepted with cmd_eof = 0 are carried into the next buffer's words.
- R8: While out_valid is high and out_ready is low, out_valid, out_data, out_cnt and out_last keep their values.
- R9: cmd_ready is 0 while a buffer is being read or a tail word is pending. A cmd_valid during that time is ignored.
- R10: When the final read of a frame leaves more than 4 bytes to send, a 4-byte word without out_last comes first. A word with the remaining 1 to 3 bytes and out_last follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Buffer command offered |
| cmd_ready | output | 1 | Block can accept a buffer command |
| cmd_addr | input | ADDR_W | Byte start address of the buffer |
| cmd_len | input | LEN_W | Buffer length in bytes, at least 1 |
| cmd_eof | input | 1 | Buffer ends the frame |
| rd_addr | output | ADDR_W | Word-aligned read address |
| rd_ready | output | 1 | Block takes the word at rd_addr this cycle |
| rd_valid | input | 1 | rd_data holds the word at rd_addr |
| rd_data | input | 8*NB | Memory word, byte lane i at address rd_addr + i |
| out_valid | output | 1 | FIFO word offered |
| out_ready | input | 1 | FIFO accepts the word |
| out_data | output | 8*NB | Packed bytes, lowest lane first |
| out_cnt | output | CNT_W | Number of valid bytes in out_data |
| out_last | output | 1 | Word ends the frame |

## Verification
A wrong held-byte count or a wrong shift shows at the next output word as bytes out of order, repeated or missing against the address-ordered byte stream. This happens within one or two reads of the fault. A wrong word counter shows as an extra or missing read handshake at the end of the buffer, or as a changed rd_addr on the next read. A lost tail or a misplaced last marker shows on the final word of the frame, where out_cnt or out_last disagrees with the byte count left in the frame. Random offsets, lengths, multi-buffer frames and random stalls on both sides expose each of these at the ports.

// File: rtl/txr_pkg.sv
package txr_pkg;

  // Per-beat position inside the current buffer
  typedef struct packed {
    logic first;   // first word read of the buffer
    logic last;    // last word read of the buffer
    logic eof;     // buffer closes the frame
  } txr_beat_t;

endpackage

// File: rtl/txr_walker.sv
module txr_walker
  import txr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12,
  parameter int NB     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_fire,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_eof,
  input  logic              beat_fire,
  output logic              active,
  output logic [ADDR_W-1:0] word_addr,
  output txr_beat_t         beat,
  output logic [$clog2(NB)-1:0] lo_lane,
  output logic [$clog2(NB)-1:0] hi_lane
);

  localparam int OFS_W = $clog2(NB);
  localparam int SPN_W = LEN_W + 1;

  logic [OFS_W-1:0]  ofs_in;
  logic [SPN_W-1:0]  span;
  logic [SPN_W-1:0]  span_end;
  logic [SPN_W-1:0]  nwords;

  logic              active_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [SPN_W-1:0]  left_q;
  logic              first_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [OFS_W-1:0]  end_q;
  logic              eof_q;

  // words touched = ceil((offset + length) / NB)
  always_comb begin
    ofs_in   = cmd_addr[OFS_W-1:0];
    span     = SPN_W'(ofs_in) + SPN_W'(cmd_len);
    span_end = span - SPN_W'(1);
    nwords   = (span + SPN_W'(NB - 1)) >> OFS_W;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      waddr_q  <= '0;
      left_q   <= '0;
      first_q  <= 1'b0;
      ofs_q    <= '0;
      end_q    <= '0;
      eof_q    <= 1'b0;
    end else if (cmd_fire) begin
      active_q <= 1'b1;
      waddr_q  <= {cmd_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
      left_q   <= nwords;
      first_q  <= 1'b1;
      ofs_q    <= ofs_in;
      end_q    <= span_end[OFS_W-1:0];
      eof_q    <= cmd_eof;
    end else if (beat_fire) begin
      waddr_q <= waddr_q + ADDR_W'(NB);
      left_q  <= left_q - SPN_W'(1);
      first_q <= 1'b0;
      if (left_q == SPN_W'(1)) begin
        active_q <= 1'b0;
      end
    end
  end

  always_comb begin
    active     = active_q;
    word_addr  = waddr_q;
    beat.first = first_q;
    beat.last  = (left_q == SPN_W'(1));
    beat.eof   = eof_q;
    lo_lane    = first_q ? ofs_q : '0;
    hi_lane    = beat.last ? end_q : OFS_W'(NB - 1);
  end

endmodule

// File: rtl/txr_lane_pick.sv
module txr_lane_pick #(
  parameter int NB = 4
) (
  input  logic [NB*8-1:0]         word_in,
  input  logic [$clog2(NB)-1:0]   lo_lane,
  input  logic [$clog2(NB)-1:0]   hi_lane,
  output logic [NB*8-1:0]         bytes_out,
  output logic [$clog2(NB+1)-1:0] cnt_out
);

  localparam int W     = NB * 8;
  localparam int OFS_W = $clog2(NB);
  localparam int CNT_W = $clog2(NB + 1);

  logic [W-1:0] shifted;

  always_comb begin
    shifted = word_in >> {lo_lane, 3'b000};
    cnt_out = CNT_W'(hi_lane) - CNT_W'(lo_lane) + CNT_W'(1);
  end

  // zero every lane at or above the kept byte count
  for (genvar j = 0; j < NB; j++) begin : g_lane
    always_comb begin
      if (CNT_W'(j) < cnt_out) begin
        bytes_out[8*j +: 8] = shifted[8*j +: 8];
      end else begin
        bytes_out[8*j +: 8] = 8'h00;
      end
    end
  end

endmodule

// File: rtl/txr_packer.sv
module txr_packer #(
  parameter int NB = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_fire,
  input  logic [NB*8-1:0]         in_bytes,
  input  logic [$clog2(NB+1)-1:0] in_cnt,
  input  logic                    in_end,
  output logic                    can_take,
  output logic                    tail_pend,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [NB*8-1:0]         out_data,
  output logic [$clog2(NB+1)-1:0] out_cnt,
  output logic                    out_last
);

  localparam int W     = NB * 8;
  localparam int CNT_W = $clog2(NB + 1);
  localparam int SUM_W = CNT_W + 1;

  logic [W-1:0]     hold_q;
  logic [CNT_W-1:0] hcnt_q;
  logic             tail_q;
  logic             ov_q;
  logic [W-1:0]     od_q;
  logic [CNT_W-1:0] oc_q;
  logic             ol_q;

  logic [2*W-1:0]   merged;
  logic [SUM_W-1:0] total;
  logic             slot_free;

  always_comb begin
    merged    = ({{W{1'b0}}, in_bytes} << {hcnt_q, 3'b000}) | {{W{1'b0}}, hold_q};
    total     = SUM_W'(hcnt_q) + SUM_W'(in_cnt);
    slot_free = !ov_q || out_ready;
    can_take  = !tail_q && slot_free;
    tail_pend = tail_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      hcnt_q <= '0;
      tail_q <= 1'b0;
      ov_q   <= 1'b0;
      od_q   <= '0;
      oc_q   <= '0;
      ol_q   <= 1'b0;
    end else begin
      if (ov_q && out_ready) begin
        ov_q <= 1'b0;
      end
      if (tail_q && slot_free) begin
        // second word of an overflowing frame end
        ov_q   <= 1'b1;
        od_q   <= hold_q;
        oc_q   <= hcnt_q;
        ol_q   <= 1'b1;
        hold_q <= '0;
        hcnt_q <= '0;
        tail_q <= 1'b0;
      end else if (in_fire) begin
        if (in_end && (total <= SUM_W'(NB))) begin
          ov_q   <= 1'b1;
          od_q   <= merged[W-1:0];
          oc_q   <= total[CNT_W-1:0];
          ol_q   <= 1'b1;
          hold_q <= '0;
          hcnt_q <= '0;
        end else if (total >= SUM_W'(NB)) begin
          ov_q   <= 1'b1;
          od_q   <= merged[W-1:0];
          oc_q   <= CNT_W'(NB);
          ol_q   <= 1'b0;
          hold_q <= merged[2*W-1:W];
          hcnt_q <= CNT_W'(total - SUM_W'(NB));
          tail_q <= in_end;
        end else begin
          hold_q <= merged[W-1:0];
          hcnt_q <= total[CNT_W-1:0];
        end
      end
    end
  end

  always_comb begin
    out_valid = ov_q;
    out_data  = od_q;
    out_cnt   = oc_q;
    out_last  = ol_q;
  end

endmodule

// File: rtl/txbuf_realign.sv
module txbuf_realign
  import txr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12,
  parameter int NB     = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [LEN_W-1:0]        cmd_len,
  input  logic                    cmd_eof,
  output logic [ADDR_W-1:0]       rd_addr,
  output logic                    rd_ready,
  input  logic                    rd_valid,
  input  logic [NB*8-1:0]         rd_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [NB*8-1:0]         out_data,
  output logic [$clog2(NB+1)-1:0] out_cnt,
  output logic                    out_last
);

  localparam int W     = NB * 8;
  localparam int OFS_W = $clog2(NB);
  localparam int CNT_W = $clog2(NB + 1);

  logic             active;
  txr_beat_t        beat;
  logic [OFS_W-1:0] lo_lane;
  logic [OFS_W-1:0] hi_lane;
  logic [W-1:0]     picked;
  logic [CNT_W-1:0] picked_cnt;
  logic             can_take;
  logic             tail_pend;
  logic             cmd_fire;
  logic             beat_fire;

  always_comb begin
    cmd_ready = !active && !tail_pend;
    cmd_fire  = cmd_valid && cmd_ready;
    rd_ready  = active && can_take;
    beat_fire = rd_valid && rd_ready;
  end

  txr_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NB(NB)) walker_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_fire  (cmd_fire),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .cmd_eof   (cmd_eof),
    .beat_fire (beat_fire),
    .active    (active),
    .word_addr (rd_addr),
    .beat      (beat),
    .lo_lane   (lo_lane),
    .hi_lane   (hi_lane)
  );

  txr_lane_pick #(.NB(NB)) pick_i (
    .word_in   (rd_data),
    .lo_lane   (lo_lane),
    .hi_lane   (hi_lane),
    .bytes_out (picked),
    .cnt_out   (picked_cnt)
  );

  txr_packer #(.NB(NB)) packer_i (
    .clk       (clk),
    .rst       (rst),
    .in_fire   (beat_fire),
    .in_bytes  (picked),
    .in_cnt    (picked_cnt),
    .in_end    (beat.last && beat.eof),
    .can_take  (can_take),
    .tail_pend (tail_pend),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_cnt   (out_cnt),
    .out_last  (out_last)
  );

endmodule

// File: rtl/txbuf_realign_chk.sv
module txbuf_realign_chk #(
  parameter int ADDR_W = 16,
  parameter int NB     = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cmd_ready,
  input logic [ADDR_W-1:0]       rd_addr,
  input logic                    rd_ready,
  input logic                    rd_valid,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [NB*8-1:0]         out_data,
  input logic [$clog2(NB+1)-1:0] out_cnt,
  input logic                    out_last
);

  localparam int OFS_W = $clog2(NB);
  localparam int CNT_W = $clog2(NB + 1);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !rd_ready && cmd_ready));

  // R2
  addr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    rd_ready |-> (rd_addr[OFS_W-1:0] == '0));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready) |=> (!rd_ready || rd_addr == $past(rd_addr) + ADDR_W'(NB)));

  // R6
  full_unless_last_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |-> (out_cnt == CNT_W'(NB)));

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_cnt != '0 && out_cnt <= CNT_W'(NB)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_cnt) && $stable(out_last)));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    rd_ready |-> !cmd_ready);

endmodule

bind txbuf_realign txbuf_realign_chk #(.ADDR_W(ADDR_W), .NB(NB)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cmd_ready (cmd_ready),
  .rd_addr   (rd_addr),
  .rd_ready  (rd_ready),
  .rd_valid  (rd_valid),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_cnt   (out_cnt),
  .out_last  (out_last)
);

// File: tb/txbuf_realign_tb_top.sv
`timescale 1ns/1ps
module txbuf_realign_tb_top;

  localparam int ADDR_W = 16;
  localparam int LEN_W  = 12;
  localparam int NB     = 4;
  localparam int CNT_W  = $clog2(NB + 1);
  localparam int LIMIT  = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [LEN_W-1:0]  cmd_len = '0;
  logic              cmd_eof = 1'b0;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_ready;
  logic              rd_valid = 1'b0;
  logic [NB*8-1:0]   rd_data;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [NB*8-1:0]   out_data;
  logic [CNT_W-1:0]  out_cnt;
  logic              out_last;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit timed_out = 0;

  // planned commands
  logic [ADDR_W-1:0] cq_a[$];
  int                cq_l[$];
  bit                cq_e[$];
  // expectations
  logic [ADDR_W-1:0] ex_addr[$];
  logic [7:0]        ex_byte[$];
  bit                ex_end[$];

  bit               stall_prev = 0;
  logic [NB*8-1:0]  sd_prev;
  logic [CNT_W-1:0] sc_prev;
  logic             sl_prev;

  function automatic logic [7:0] byte_at(input logic [ADDR_W-1:0] a);
    logic [7:0] m;
    m = a[15:8] * 8'd29;
    return a[7:0] ^ m ^ 8'h5A;
  endfunction

  function automatic logic [NB*8-1:0] mk_word(input logic [ADDR_W-1:0] wa);
    logic [NB*8-1:0] w;
    for (int i = 0; i < NB; i++) w[8*i +: 8] = byte_at(wa + ADDR_W'(i));
    return w;
  endfunction

  assign rd_data = mk_word(rd_addr);

  always #2 clk = ~clk;

  txbuf_realign #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NB(NB)) dut_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_eof(cmd_eof),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_cnt(out_cnt), .out_last(out_last)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic plan(input logic [ADDR_W-1:0] a, input int l, input bit e);
    cq_a.push_back(a); cq_l.push_back(l); cq_e.push_back(e);
  endtask

  // expected reads and bytes for one accepted buffer (R2 R3 R4 R5 R7)
  task automatic expect_buf(input logic [ADDR_W-1:0] a, input int l, input bit e);
    int o  = int'(a) % NB;
    int nw = (o + l + NB - 1) / NB;
    logic [ADDR_W-1:0] wa = a & ~ADDR_W'(NB - 1);
    for (int i = 0; i < nw; i++) ex_addr.push_back(wa + ADDR_W'(NB * i));
    for (int i = 0; i < l; i++) begin
      ex_byte.push_back(byte_at(a + ADDR_W'(i)));
      ex_end.push_back(e && (i == l - 1));
    end
  endtask

  task automatic step(input int rv_pct, input int or_pct);
    @(negedge clk);
    cyc++;
    if (cyc > LIMIT) timed_out = 1;
    rd_valid  = ($urandom % 100) < rv_pct;
    out_ready = ($urandom % 100) < or_pct;
    if (cq_a.size() > 0) begin
      cmd_valid = 1'b1; cmd_addr = cq_a[0]; cmd_len = LEN_W'(cq_l[0]); cmd_eof = cq_e[0];
    end else if (!cmd_ready && ($urandom % 3 == 0)) begin
      // stray command while busy, must be ignored (R9)
      cmd_valid = 1'b1; cmd_addr = ADDR_W'($urandom); cmd_len = LEN_W'(5); cmd_eof = 1'b1;
    end else begin
      cmd_valid = 1'b0;
    end
    #1;
    // R8: stalled word unchanged
    if (stall_prev) begin
      check(out_valid && out_data == sd_prev && out_cnt == sc_prev && out_last == sl_prev,
            "R8 stalled word changed", int'(out_data), int'(sd_prev));
    end
    stall_prev = out_valid && !out_ready;
    sd_prev = out_data; sc_prev = out_cnt; sl_prev = out_last;
    // command handshake
    if (cmd_valid && cmd_ready) begin
      check(cq_a.size() > 0, "R9 stray command accepted", 1, 0);
      if (cq_a.size() > 0) begin
        expect_buf(cq_a[0], cq_l[0], cq_e[0]);
        void'(cq_a.pop_front()); void'(cq_l.pop_front()); void'(cq_e.pop_front());
      end
    end
    // read handshake (R2 R3)
    if (rd_valid && rd_ready) begin
      if (ex_addr.size() == 0) begin
        check(0, "R3 extra read", int'(rd_addr), -1);
      end else begin
        logic [ADDR_W-1:0] ea = ex_addr.pop_front();
        check(rd_addr == ea, "R2 read address", int'(rd_addr), int'(ea));
      end
    end
    // output handshake (R4 R5 R6 R7 R10)
    if (out_valid && out_ready) begin
      int n = 0;
      bit el = 0;
      bit dok = 1;
      logic [NB*8-1:0] ed = '0;
      while (n < NB && n < ex_byte.size()) begin
        ed[8*n +: 8] = ex_byte[n];
        el = ex_end[n];
        n++;
        if (el) break;
      end
      if (n == 0) begin
        check(0, "R5 unexpected output word", int'(out_data), -1);
      end else begin
        for (int i = 0; i < n; i++) if (out_data[8*i +: 8] != ed[8*i +: 8]) dok = 0;
        check(dok, "R4 R5 packed bytes", int'(out_data), int'(ed));
        check(int'(out_cnt) == n, "R6 R10 byte count", int'(out_cnt), n);
        check(out_last == el, "R7 last marker", int'(out_last), int'(el));
        for (int i = 0; i < n; i++) begin
          void'(ex_byte.pop_front()); void'(ex_end.pop_front());
        end
      end
    end
  endtask

  task automatic drain(input int rv_pct, input int or_pct);
    while (!timed_out && (cq_a.size() > 0 || ex_addr.size() > 0 || ex_byte.size() > 0 || out_valid))
      step(rv_pct, or_pct);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1
    check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    check(!rd_ready,  "R1 rd_ready after reset", int'(rd_ready), 0);
    check(cmd_ready,  "R1 cmd_ready after reset", int'(cmd_ready), 1);

    // directed corner cases
    plan(16'h0FF2, 15, 1);   // R3 R4: 5 reads, 4+4+4+3 bytes
    plan(16'h0100, 4, 1);    // aligned single word
    plan(16'h0203, 1, 1);    // one byte at top lane
    plan(16'h0301, 3, 0);    // R7: carried into next buffer
    plan(16'h0311, 2, 1);
    plan(16'h0402, 3, 0);    // R10: 3 held + 4 at frame end
    plan(16'h0500, 4, 1);
    plan(16'h0601, 2, 0);    // R7: multi-buffer, many tiny pieces
    plan(16'h0703, 1, 0);
    plan(16'h0802, 2, 1);
    drain(100, 100);
    drain(60, 40);
    plan(16'h0A01, 9, 1);    // R8 heavy backpressure
    drain(100, 15);

    // constrained random frames
    for (int f = 0; f < 300 && !timed_out; f++) begin
      int nb = 1 + ($urandom % 3);
      for (int b = 0; b < nb; b++) begin
        plan(ADDR_W'($urandom) & 16'h7FFF, 1 + ($urandom % 40), b == nb - 1);
      end
      if (f % 10 == 9) drain(20 + ($urandom % 80), 20 + ($urandom % 80));
    end
    drain(70, 70);

    check(!timed_out, "R3 watchdog expired", cyc, LIMIT);
    check(ex_addr.size() == 0, "R3 reads missing", ex_addr.size(), 0);
    check(ex_byte.size() == 0, "R5 bytes missing", ex_byte.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule